// File: doc/BRIEF.md
# Vectored Edge/Level Interrupt Controller

This block collects up to 64 interrupt input lines and steers each one onto an output line. Each input is set to edge or level capture, may be masked, and owns a byte-wide vector that names the output line it drives. The controller keeps pending-request, in-service, previous-level, mask, edge-mode and polarity state, plus a message-enable word and a byte-wide route table. The polarity, message-enable and route state are storage only and have no effect on the outputs.

Inputs are sampled on every clock. A change on an input becomes an assertion or deassertion event for that bit. Register writes can also raise events: a mask write, a clear write and a status write. In one cycle the block services at most one assertion, which is the lowest-numbered eligible bit, and at most one deassertion, which is the lowest-numbered bit still in service. Each serviced bit drives its vectored output line high or low through a register, so the line changes on the clock edge that sees the event.

Software reaches the state through a synchronous bus with combinational read data and byte addresses. Every 64-bit register appears as a low word at offset +0 and a high word at offset +4. The two byte tables sit in pages of 64 entries each.

Top module: `vic_top`

## Requirements
- R1: A read at offset 0x000 returns VERSION in bits 15:0 and NUM_IN-1 in bits 31:16.
- R2: After reset, all outputs are low and the mask (0x008/0x00C) reads all ones. Every route entry (0x100+i) reads 1 and every vector entry (0x200+i) reads 0. Edge mode (0x010), message enable (0x020), status (0x028) and polarity (0x030) read zero.
- R3: For a bit with edge mode set (edge bit = 1), the request is set only when the input is seen high after a low sample. A falling input leaves that request set.
- R4: For a bit in level mode (edge bit = 0), the request follows each input change: it is set on a change to high and cleared on a change to low.
- R5: An assertion event picks the lowest-numbered bit of (event bits AND request AND NOT mask). It sets that bit in service and drives high the output named by its vector. Other eligible bits of the same event are not serviced.
- R6: A deassertion event picks the lowest-numbered bit of (event bits AND in-service). It clears that bit from service and drives low the output named by its vector.
- R7: A write to a mask word evaluates the bits that go from masked to unmasked as an assertion event. Bits that go from unmasked to masked are evaluated as a deassertion event.
- R8: A write to a clear word (0x018/0x01C) acts only when at least one written bit is in edge mode. It then clears the request of every written bit and evaluates them as a deassertion event, and in addition removes every written bit from service. Otherwise the write has no effect.
- R9: The status word (0x028/0x02C) reads in-service AND NOT mask. A write to it loads the in-service bits of that half directly.
- R10: A write to one 32-bit half of a 64-bit register leaves the other half unchanged.
- R11: Route entries (0x100-0x13F) and vector entries (0x200-0x23F) are written from data bits 7:0 and read back zero-extended. Offsets outside the map read zero and ignore writes.
- R12: A vector value of NUM_OUT or more drives no output line, while the in-service state still updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Interrupt input levels |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | NUM_OUT | Registered output lines |

## Verification
The bench builds the block with NUM_IN = 40, NUM_OUT = 8 and VERSION = 0x0102. Forty inputs put live bits in the high register words, so the half-word paths and an input above bit 31 are both exercised. The identification word then carries a count that differs from the default. With eight output lines, a vector value of 0x20 falls outside the output range, which tests that such a vector drives nothing while in-service state still moves.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int REG_W  = 64;
    localparam int HALF_W = 32;
    localparam int TAB_N  = 64;
    localparam int IDX_W  = 6;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_IDENT    = 12'h000;
    localparam logic [ADDR_W-1:0] A_MASK_LO  = 12'h008;
    localparam logic [ADDR_W-1:0] A_MASK_HI  = 12'h00C;
    localparam logic [ADDR_W-1:0] A_EDGE_LO  = 12'h010;
    localparam logic [ADDR_W-1:0] A_EDGE_HI  = 12'h014;
    localparam logic [ADDR_W-1:0] A_CLR_LO   = 12'h018;
    localparam logic [ADDR_W-1:0] A_CLR_HI   = 12'h01C;
    localparam logic [ADDR_W-1:0] A_MSGEN_LO = 12'h020;
    localparam logic [ADDR_W-1:0] A_MSGEN_HI = 12'h024;
    localparam logic [ADDR_W-1:0] A_STAT_LO  = 12'h028;
    localparam logic [ADDR_W-1:0] A_STAT_HI  = 12'h02C;
    localparam logic [ADDR_W-1:0] A_POL_LO   = 12'h030;
    localparam logic [ADDR_W-1:0] A_POL_HI   = 12'h034;
    localparam logic [ADDR_W-1:0] A_ROUTE    = 12'h100;
    localparam logic [ADDR_W-1:0] A_VECT     = 12'h200;

    // Result of a lowest-set-bit search.
    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Per-bit input events of one cycle.
    typedef struct packed {
        logic [REG_W-1:0] rise;
        logic [REG_W-1:0] fall;
    } evt_t;

    // Register-side effects on the service stage.
    typedef struct packed {
        logic [REG_W-1:0] unmasked;
        logic [REG_W-1:0] masked;
        logic [REG_W-1:0] mask_nx;
        logic             clr_fire;
        logic [REG_W-1:0] clr_bits;
        logic             stat_load;
        logic [REG_W-1:0] stat_val;
    } regfx_t;

    function automatic pick_t lowest_one(input logic [REG_W-1:0] v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = REG_W - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [REG_W-1:0] merge_half(input logic [REG_W-1:0] old,
                                                    input logic hi,
                                                    input logic [HALF_W-1:0] d);
        return hi ? {d, old[HALF_W-1:0]} : {old[REG_W-1:HALF_W], d};
    endfunction

    function automatic logic [REG_W-1:0] place_half(input logic hi,
                                                    input logic [HALF_W-1:0] d);
        return hi ? {d, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, d};
    endfunction

    function automatic logic in_page(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
        return a[ADDR_W-1:IDX_W] == base[ADDR_W-1:IDX_W];
    endfunction

endpackage

// File: rtl/vic_capture.sv
module vic_capture
    import vic_pkg::*;
#(
    parameter int NUM_IN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic [REG_W-1:0]  edge_mode,
    input  logic              clr_fire,
    input  logic [REG_W-1:0]  clr_bits,
    output logic [REG_W-1:0]  req_q,
    output logic [REG_W-1:0]  req_nx,
    output evt_t              ev
);

    logic [REG_W-1:0] lvl;
    logic [REG_W-1:0] last_q;
    logic [REG_W-1:0] chg;
    logic [REG_W-1:0] req_upd;

    generate
        if (NUM_IN < REG_W) begin : g_pad
            assign lvl = {{(REG_W-NUM_IN){1'b0}}, irq_in};
        end else begin : g_full
            assign lvl = irq_in;
        end
    endgenerate

    always_comb begin
        chg     = lvl ^ last_q;
        ev.rise = chg & lvl;
        ev.fall = chg & ~lvl;
        // Level bits drop on a fall; any rise sets (edge or level).
        req_upd = (req_q & ~(ev.fall & ~edge_mode)) | ev.rise;
        req_nx  = clr_fire ? (req_upd & ~clr_bits) : req_upd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            req_q  <= '0;
        end else begin
            last_q <= lvl;
            req_q  <= req_nx;
        end
    end

endmodule

// File: rtl/vic_regbank.sv
module vic_regbank
    import vic_pkg::*;
#(
    parameter int          NUM_IN  = 64,
    parameter logic [15:0] VERSION = 16'h0001
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         we,
    input  logic [HALF_W-1:0]            wdata,
    input  logic [REG_W-1:0]             isr_q,
    output logic [HALF_W-1:0]            rdata,
    output logic [REG_W-1:0]             mask_q,
    output logic [REG_W-1:0]             edge_q,
    output logic [TAB_N-1:0][7:0]        vec_tab,
    output regfx_t                       fx
);

    localparam logic [15:0] COUNT_M1 = 16'(NUM_IN - 1);

    logic [REG_W-1:0]      msgen_q;
    logic [REG_W-1:0]      pol_q;
    logic [TAB_N-1:0][7:0] route_q;
    logic [TAB_N-1:0][7:0] vec_q;

    logic             hi;
    logic [IDX_W-1:0] tidx;
    logic             route_hit;
    logic             vec_hit;
    logic             wr_mask;
    logic             wr_clr;
    logic             wr_stat;
    logic [REG_W-1:0] mask_new;
    logic [REG_W-1:0] visible;

    assign hi        = addr[2];
    assign tidx      = addr[IDX_W-1:0];
    assign route_hit = in_page(addr, A_ROUTE);
    assign vec_hit   = in_page(addr, A_VECT);
    assign wr_mask   = we && (addr == A_MASK_LO || addr == A_MASK_HI);
    assign wr_clr    = we && (addr == A_CLR_LO || addr == A_CLR_HI);
    assign wr_stat   = we && (addr == A_STAT_LO || addr == A_STAT_HI);
    assign mask_new  = merge_half(mask_q, hi, wdata);
    assign visible   = isr_q & ~mask_q;
    assign vec_tab   = vec_q;

    always_comb begin
        fx.mask_nx   = wr_mask ? mask_new : mask_q;
        fx.unmasked  = wr_mask ? (mask_q & ~mask_new) : '0;
        fx.masked    = wr_mask ? (~mask_q & mask_new) : '0;
        fx.clr_bits  = place_half(hi, wdata);
        fx.clr_fire  = wr_clr && (|(fx.clr_bits & edge_q));
        fx.stat_load = wr_stat;
        fx.stat_val  = merge_half(isr_q, hi, wdata);
    end

    always_comb begin
        rdata = '0;
        if (route_hit) begin
            rdata = {24'b0, route_q[tidx]};
        end else if (vec_hit) begin
            rdata = {24'b0, vec_q[tidx]};
        end else begin
            case (addr)
                A_IDENT:    rdata = {COUNT_M1, VERSION};
                A_MASK_LO:  rdata = mask_q[HALF_W-1:0];
                A_MASK_HI:  rdata = mask_q[REG_W-1:HALF_W];
                A_EDGE_LO:  rdata = edge_q[HALF_W-1:0];
                A_EDGE_HI:  rdata = edge_q[REG_W-1:HALF_W];
                A_MSGEN_LO: rdata = msgen_q[HALF_W-1:0];
                A_MSGEN_HI: rdata = msgen_q[REG_W-1:HALF_W];
                A_STAT_LO:  rdata = visible[HALF_W-1:0];
                A_STAT_HI:  rdata = visible[REG_W-1:HALF_W];
                A_POL_LO:   rdata = pol_q[HALF_W-1:0];
                A_POL_HI:   rdata = pol_q[REG_W-1:HALF_W];
                default:    rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            edge_q  <= '0;
            msgen_q <= '0;
            pol_q   <= '0;
            route_q <= {TAB_N{8'h01}};
            vec_q   <= '0;
        end else if (we) begin
            if (route_hit) route_q[tidx] <= wdata[7:0];
            if (vec_hit)   vec_q[tidx]   <= wdata[7:0];
            case (addr)
                A_MASK_LO, A_MASK_HI:   mask_q  <= mask_new;
                A_EDGE_LO, A_EDGE_HI:   edge_q  <= merge_half(edge_q, hi, wdata);
                A_MSGEN_LO, A_MSGEN_HI: msgen_q <= merge_half(msgen_q, hi, wdata);
                A_POL_LO, A_POL_HI:     pol_q   <= merge_half(pol_q, hi, wdata);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vic_service.sv
module vic_service
    import vic_pkg::*;
#(
    parameter int NUM_OUT = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  evt_t                  ev,
    input  regfx_t                fx,
    input  logic [REG_W-1:0]      req_nx,
    input  logic [TAB_N-1:0][7:0] vec_tab,
    output logic [REG_W-1:0]      isr_q,
    output logic [NUM_OUT-1:0]    irq_out
);

    logic [REG_W-1:0]   up_set;
    logic [REG_W-1:0]   dn_set;
    pick_t              up;
    pick_t              dn;
    logic [7:0]         up_vec;
    logic [7:0]         dn_vec;
    logic [REG_W-1:0]   isr_nx;
    logic [NUM_OUT-1:0] out_nx;

    always_comb begin
        up_set = (ev.rise | fx.unmasked) & req_nx & ~fx.mask_nx;
        dn_set = (ev.fall | fx.masked | (fx.clr_fire ? fx.clr_bits : '0)) & isr_q;
        up     = lowest_one(up_set);
        dn     = lowest_one(dn_set);
        up_vec = vec_tab[up.idx];
        dn_vec = vec_tab[dn.idx];

        isr_nx = isr_q;
        if (up.hit) isr_nx[up.idx] = 1'b1;
        if (dn.hit) isr_nx[dn.idx] = 1'b0;
        if (fx.clr_fire) isr_nx = isr_nx & ~fx.clr_bits;
        if (fx.stat_load) isr_nx = fx.stat_val;

        // Deassertion is applied after assertion on a shared line.
        out_nx = irq_out;
        for (int k = 0; k < NUM_OUT; k++) begin
            if (up.hit && up_vec == 8'(k)) out_nx[k] = 1'b1;
            if (dn.hit && dn_vec == 8'(k)) out_nx[k] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q   <= '0;
            irq_out <= '0;
        end else begin
            isr_q   <= isr_nx;
            irq_out <= out_nx;
        end
    end

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int          NUM_IN  = 64,
    parameter int          NUM_OUT = 32,
    parameter logic [15:0] VERSION = 16'h0001
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IN-1:0]  irq_in,
    input  logic [11:0]        bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_OUT-1:0] irq_out
);

    logic [REG_W-1:0]      mask_q;
    logic [REG_W-1:0]      edge_q;
    logic [REG_W-1:0]      req_q;
    logic [REG_W-1:0]      req_nx;
    logic [REG_W-1:0]      isr_q;
    logic [TAB_N-1:0][7:0] vec_tab;
    evt_t                  ev;
    regfx_t                fx;

    vic_regbank #(
        .NUM_IN  (NUM_IN),
        .VERSION (VERSION)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .isr_q   (isr_q),
        .rdata   (bus_rdata),
        .mask_q  (mask_q),
        .edge_q  (edge_q),
        .vec_tab (vec_tab),
        .fx      (fx)
    );

    vic_capture #(
        .NUM_IN (NUM_IN)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .edge_mode (edge_q),
        .clr_fire  (fx.clr_fire),
        .clr_bits  (fx.clr_bits),
        .req_q     (req_q),
        .req_nx    (req_nx),
        .ev        (ev)
    );

    vic_service #(
        .NUM_OUT (NUM_OUT)
    ) u_svc (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .fx      (fx),
        .req_nx  (req_nx),
        .vec_tab (vec_tab),
        .isr_q   (isr_q),
        .irq_out (irq_out)
    );

endmodule

// File: rtl/vic_checker.sv
module vic_checker
    import vic_pkg::*;
#(
    parameter int          NUM_IN  = 64,
    parameter int          NUM_OUT = 32,
    parameter logic [15:0] VERSION = 16'h0001
) (
    input logic               clk,
    input logic               rst,
    input logic [11:0]        bus_addr,
    input logic               bus_we,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NUM_OUT-1:0] irq_out,
    input logic [REG_W-1:0]   mask_q,
    input logic [REG_W-1:0]   edge_q,
    input logic [REG_W-1:0]   req_q,
    input logic [REG_W-1:0]   isr_q
);

    a_r1_ident_word: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_IDENT) |-> (bus_rdata == {16'(NUM_IN - 1), VERSION}));

    a_r2_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask_q == '1 && isr_q == '0 && irq_out == '0));

    a_r5_one_line_up: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_out & ~$past(irq_out)) <= 1);

    a_r6_one_line_down: assert property (@(posedge clk) disable iff (rst)
        $countones(~irq_out & $past(irq_out)) <= 1);

    a_r8_clear_drops_req: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CLR_LO && (|(bus_wdata & edge_q[31:0])))
        |=> ((req_q[31:0] & $past(bus_wdata)) == '0));

    a_r10_mask_hi_kept: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_MASK_LO) |=> $stable(mask_q[63:32]));

endmodule

bind vic_top vic_checker #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .VERSION (VERSION)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .mask_q    (mask_q),
    .edge_q    (edge_q),
    .req_q     (req_q),
    .isr_q     (isr_q)
);

// File: tb/vic_top_bench.sv
module vic_top_bench;

    localparam int NI = 40;
    localparam int NO = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NI-1:0] irq = '0;
    logic [11:0]   addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NO-1:0] outs;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    vic_top #(.NUM_IN(NI), .NUM_OUT(NO), .VERSION(16'h0102)) u_vic_top (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_out   (outs)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1 d = rdata;
    endtask

    task automatic pin(input int b, input logic v);
        @(negedge clk);
        irq[b] = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R2 outputs", 32'(outs), 32'h0);
        rd(12'h008, d); chk("R2 mask lo", d, 32'hFFFF_FFFF);
        rd(12'h00C, d); chk("R2 mask hi", d, 32'hFFFF_FFFF);
        rd(12'h100, d); chk("R2 route0", d, 32'h1);
        rd(12'h13F, d); chk("R2 route63", d, 32'h1);
        rd(12'h205, d); chk("R2 vec5", d, 32'h0);
        rd(12'h010, d); chk("R2 edge", d, 32'h0);
        rd(12'h020, d); chk("R2 msgen", d, 32'h0);
        rd(12'h028, d); chk("R2 status", d, 32'h0);
        rd(12'h034, d); chk("R2 polarity", d, 32'h0);
    endtask

    task automatic t_ident();
        logic [31:0] d;
        rd(12'h000, d); chk("R1 ident", d, 32'h0027_0102);
    endtask

    task automatic t_halves();
        logic [31:0] d;
        wr(12'h030, 32'hA5A5_A5A5);
        wr(12'h034, 32'h5A5A_5A5A);
        wr(12'h030, 32'h1111_1111);
        rd(12'h034, d); chk("R10 pol hi kept", d, 32'h5A5A_5A5A);
        rd(12'h030, d); chk("R10 pol lo new", d, 32'h1111_1111);
        wr(12'h024, 32'h0000_00F0);
        rd(12'h020, d); chk("R10 msgen lo kept", d, 32'h0);
    endtask

    task automatic t_tables();
        logic [31:0] d;
        wr(12'h103, 32'hFFFF_FF7E);
        rd(12'h103, d); chk("R11 route3", d, 32'h7E);
        wr(12'h20A, 32'h0000_0005);
        rd(12'h20A, d); chk("R11 vec10", d, 32'h05);
        wr(12'h140, 32'h0000_0033);
        rd(12'h140, d); chk("R11 beyond route", d, 32'h0);
        wr(12'h0F0, 32'h1234_5678);
        rd(12'h0F0, d); chk("R11 unmapped", d, 32'h0);
        rd(12'h100, d); chk("R11 route0 untouched", d, 32'h1);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(12'h202, 32'h3);
        wr(12'h204, 32'h6);
        wr(12'h008, 32'hFFFF_FFEB);
        chk("R7 unmask without request", 32'(outs), 32'h0);
        @(negedge clk);
        irq[2] = 1'b1; irq[4] = 1'b1;
        @(negedge clk);
        chk("R5 lowest bit line", 32'(outs), 32'h08);
        rd(12'h028, d); chk("R5 only lowest in service", d, 32'h04);
        pin(2, 1'b0);
        chk("R6 line dropped", 32'(outs), 32'h00);
        rd(12'h028, d); chk("R6 service cleared", d, 32'h0);
        pin(4, 1'b0);
        pin(4, 1'b1);
        chk("R4 level rise serviced", 32'(outs), 32'h40);
        pin(4, 1'b0);
        chk("R4 level fall drops line", 32'(outs), 32'h00);
        wr(12'h008, 32'hFFFF_FFFB);
        wr(12'h008, 32'hFFFF_FFEB);
        chk("R4 request cleared by low", 32'(outs), 32'h00);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(12'h010, 32'h80);
        wr(12'h207, 32'h1);
        pin(7, 1'b1);
        chk("R3 masked edge silent", 32'(outs), 32'h0);
        pin(7, 1'b0);
        wr(12'h008, 32'hFFFF_FF6B);
        chk("R3 R7 held edge request", 32'(outs), 32'h02);
        rd(12'h028, d); chk("R9 status read", d, 32'h80);
        wr(12'h008, 32'hFFFF_FFEB);
        chk("R7 mask deasserts", 32'(outs), 32'h00);
        wr(12'h028, 32'h80);
        rd(12'h028, d); chk("R9 loaded but masked", d, 32'h0);
        wr(12'h008, 32'hFFFF_FF6B);
        chk("R7 reassert after unmask", 32'(outs), 32'h02);
        rd(12'h028, d); chk("R9 status visible", d, 32'h80);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        pin(2, 1'b1);
        chk("R5 second line up", 32'(outs), 32'h0A);
        wr(12'h018, 32'h04);
        chk("R8 level-only clear ignored", 32'(outs), 32'h0A);
        rd(12'h028, d); chk("R8 service kept", d, 32'h84);
        wr(12'h018, 32'h84);
        chk("R8 R6 one deassert per clear", 32'(outs), 32'h02);
        rd(12'h028, d); chk("R8 service cleared", d, 32'h0);
        wr(12'h008, 32'hFFFF_FFEB);
        wr(12'h008, 32'hFFFF_FF6B);
        rd(12'h028, d); chk("R8 edge request cleared", d, 32'h0);
        pin(2, 1'b0);
    endtask

    task automatic t_range();
        logic [31:0] d;
        wr(12'h209, 32'h20);
        wr(12'h008, 32'hFFFF_FD6B);
        pin(9, 1'b1);
        chk("R12 wide vector drives nothing", 32'(outs), 32'h02);
        rd(12'h028, d); chk("R12 service still set", d, 32'h200);
        pin(9, 1'b0);
    endtask

    task automatic t_high();
        logic [31:0] d;
        wr(12'h223, 32'h0);
        wr(12'h00C, 32'hFFFF_FFF7);
        rd(12'h008, d); chk("R10 mask lo kept", d, 32'hFFFF_FD6B);
        pin(35, 1'b1);
        chk("R5 high input line", 32'(outs), 32'h03);
        rd(12'h02C, d); chk("R9 status hi", d, 32'h8);
        pin(35, 1'b0);
        chk("R6 high input dropped", 32'(outs), 32'h02);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ident();
        t_halves();
        t_tables();
        t_level();
        t_edge();
        t_clear();
        t_range();
        t_high();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule